// File: doc/BRIEF.md
# Idle-Aware Automatic Clock Gater

This block wraps a small sequential engine and turns its clock off whenever the engine has nothing to do. The engine is a state machine with one idle state and two working states (ready and run). A purely combinational scout looks at the engine's current state, its next state and the incoming request. It keeps the clock running in every case except one: the engine sits idle now and will still be idle after the coming edge. A latch-based clock-gate cell turns that enable into a gated clock with no partial pulses. The latch is transparent while the clock is low.

Requests arrive on a valid/ready pair. The requester raises `req_valid` and holds it until a rising edge at which `req_ready` is also high. `req_ready` is high only while the engine is idle, so a request held during a busy period waits without being lost. It is taken on the first edge after the engine returns to idle. Because a raised `req_valid` reopens the gate during the low phase, the engine sees the request on the very next rising edge.

A test input forces the gate open. A saturating counter reports how many clock edges were suppressed.

Top module: `idle_clock_gater`

## Requirements
- R1: While reset is low and on release, `busy`=0, `req_ready`=1, `done`=0 and `gated_cycles`=0.
- R2: In a cycle where the engine is idle, `req_valid`=0 and `test_en`=0, `clk_on` is 0 at the next rising edge, and the engine does not change state.
- R3: While `busy` is 1, `clk_on` is 1.
- R4: In an idle cycle with `req_valid`=1, `clk_on` is 1 and the request is accepted on that edge, so `busy` is 1 in the following cycle.
- R5: While `test_en` is 1, `clk_on` is 1 whatever the engine state.
- R6: An accepted request produces exactly 1 + RUN_LEN busy cycles: one ready cycle followed by RUN_LEN run cycles. The engine then returns to idle.
- R7: `done` is 1 for exactly one cycle per request, the last run cycle, and is 0 in every other cycle.
- R8: `gated_cycles` increments by one on each rising clock edge at which `clk_on` was 0. It holds at all other edges and saturates at its all-ones value.
- R9: `req_valid` is ignored while `busy` is 1. A request held through a busy period is accepted on the first edge after the engine returns to idle, and `busy` is 1 again in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Forces the clock gate open |
| req_valid | input | 1 | Request from the bus, held until accepted |
| req_ready | output | 1 | High while the engine is idle and can accept |
| busy | output | 1 | Engine is in a working state |
| done | output | 1 | One-cycle pulse in the last run cycle |
| clk_on | output | 1 | Latched gate enable currently applied to the engine clock |
| gated_cycles | output | CNT_W | Saturating count of suppressed clock edges |

## Verification
`clk_on` for a cycle follows the inputs driven at that cycle's falling edge. It is due before the next rising edge, with no register on the path. `busy`, `done` and `req_ready` show the engine state reached at the previous rising edge. `gated_cycles` reflects every suppressed edge up to the previous rising edge. Inputs are driven at each falling edge, and a reference model pushes the expected values for that cycle into a queue. A monitor pops the queue and compares the outputs 1 ns before the next rising edge, so every result is read in the cycle it is due.

// File: rtl/icg_pkg.sv
package icg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/gate_scout.sv
// Combinational enable: the clock runs unless the engine stays idle across the next edge.
module gate_scout
  import icg_pkg::*;
(
  input  eng_state_e cur_state,
  input  eng_state_e nxt_state,
  input  logic       force_on,
  output logic       enable
);
  logic stay_idle;
  always_comb begin
    stay_idle = (cur_state == ST_IDLE) && (nxt_state == ST_IDLE);
    enable    = force_on || !stay_idle;
  end
endmodule

// File: rtl/latch_clock_gate.sv
// Enable captured while the clock is low, then ANDed with the clock.
module latch_clock_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_latched,
  output logic gclk_o
);
  always_latch begin
    if (!clk_i) en_latched = en_i;
  end
  assign gclk_o = clk_i & en_latched;
endmodule

// File: rtl/demo_engine.sv
// Request/busy/done sequencer: idle -> ready -> run (RUN_LEN cycles) -> idle.
module demo_engine
  import icg_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic       gclk,
  input  logic       rst_n,
  input  logic       req_valid,
  output eng_state_e state_q,
  output eng_state_e state_d,
  output logic       last_run
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign last_run = (state_q == ST_RUN) && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_READY;
      ST_READY: state_d = ST_RUN;
      ST_RUN:   if (cnt_q == LAST) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
    end
  end
endmodule

// File: rtl/cycle_meter.sv
// Saturating count of edges suppressed by the gate.
module cycle_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (!gate_on && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/idle_clock_gater.sv
module idle_clock_gater
  import icg_pkg::*;
#(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic             clk_on,
  output logic [CNT_W-1:0] gated_cycles
);
  eng_state_e cur_st, nxt_st;
  logic       scout_en;
  logic       gclk;
  logic       last_run;

  gate_scout u_scout (
    .cur_state (cur_st),
    .nxt_state (nxt_st),
    .force_on  (test_en),
    .enable    (scout_en)
  );

  latch_clock_gate u_icg (
    .clk_i      (clk),
    .en_i       (scout_en),
    .en_latched (clk_on),
    .gclk_o     (gclk)
  );

  demo_engine #(.RUN_LEN(RUN_LEN)) u_engine (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .state_q   (cur_st),
    .state_d   (nxt_st),
    .last_run  (last_run)
  );

  cycle_meter #(.CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_on (clk_on),
    .count   (gated_cycles)
  );

  assign busy      = (cur_st != ST_IDLE);
  assign req_ready = (cur_st == ST_IDLE);
  assign done      = last_run;
endmodule

// File: rtl/idle_clock_gater_chk.sv
module idle_clock_gater_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             clk_on,
  input logic [CNT_W-1:0] gated_cycles
);
  // R2
  idle_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid && !test_en) |-> !clk_on);
  // R3
  busy_gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> clk_on);
  // R5
  test_gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> clk_on);
  // R4
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  meter_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && gated_cycles != '1) |=> gated_cycles == $past(gated_cycles) + 1'b1);
  // R8
  meter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on |=> $stable(gated_cycles));
endmodule

bind idle_clock_gater idle_clock_gater_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .test_en      (test_en),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .busy         (busy),
  .done         (done),
  .clk_on       (clk_on),
  .gated_cycles (gated_cycles)
);

// File: tb/test_idle_clock_gater.sv
module test_idle_clock_gater;
  localparam int RUN_LEN = 3;
  localparam int CNT_W   = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready, busy, done, clk_on;
  logic [CNT_W-1:0] gated_cycles;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic on;
    logic bsy;
    logic dn;
    logic rdy;
    logic [CNT_W-1:0] cnt;
    string tag;
  } exp_t;
  exp_t q[$];

  // reference model state
  int m_state = 0;   // 0 idle, 1 ready, 2 run
  int m_cnt = 0;
  logic [CNT_W-1:0] m_gated = '0;

  always #5 clk = ~clk;

  idle_clock_gater #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) i_idle_clock_gater (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .req_valid(req_valid),
    .req_ready(req_ready), .busy(busy), .done(done), .clk_on(clk_on),
    .gated_cycles(gated_cycles)
  );

  task automatic check1(string tag, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: called at a falling edge, drives inputs and pushes this cycle's expectations.
  task automatic step(logic req, logic tm, string tag);
    exp_t e;
    req_valid = req;
    test_en   = tm;
    e.bsy = (m_state != 0);
    e.rdy = (m_state == 0);
    e.dn  = (m_state == 2) && (m_cnt == RUN_LEN - 1);
    e.on  = tm || e.bsy || req;
    e.cnt = m_gated;
    e.tag = tag;
    q.push_back(e);
    if (!e.on) begin
      if (m_gated != CMAX) m_gated = m_gated + 1'b1;
    end else begin
      case (m_state)
        0: if (req) m_state = 1;
        1: begin m_state = 2; m_cnt = 0; end
        default: if (m_cnt == RUN_LEN - 1) m_state = 0; else m_cnt++;
      endcase
    end
    @(negedge clk);
  endtask

  // Monitor: compares just before each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check1(e.tag, clk_on, e.on, "clk_on");
        check1(e.tag, busy, e.bsy, "busy");
        check1(e.tag, done, e.dn, "done");
        check1(e.tag, req_ready, e.rdy, "req_ready");
        tests++;
        if (gated_cycles !== e.cnt) begin
          fails++;
          $display("FAIL %s gated_cycles actual=%0d expected=%0d t=%0t", e.tag,
                   gated_cycles, e.cnt, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check1("R1", busy, 1'b0, "busy");
    check1("R1", req_ready, 1'b1, "req_ready");
    check1("R1", done, 1'b0, "done");
    tests++;
    if (gated_cycles !== '0) begin
      fails++;
      $display("FAIL R1 gated_cycles actual=%0d expected=0", gated_cycles);
    end
    rst_n = 1'b1;
    // R2: idle with no request gates off
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2");
    // R4: request reopens the gate and is accepted
    step(1'b1, 1'b0, "R4");
    // R3 R6 R7: busy period, gate open, single done
    for (int i = 0; i < RUN_LEN + 1; i++) step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R2");
    // R5: test mode keeps the gate open while idle
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R5");
    // R9: request held through a busy period
    step(1'b1, 1'b0, "R4");
    for (int i = 0; i < RUN_LEN + 3; i++) step(1'b1, 1'b0, "R9");
    for (int i = 0; i < RUN_LEN + 1; i++) step(1'b0, 1'b1, "R3");
    // R8: saturation of the gated-edge counter
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule